// File: doc/BRIEF.md
# Parallel Flash Programming Controller

This block is the device-side engine of a pin-driven parallel programming port for a 4096-byte code array. An external programmer holds the part in its programming state with a reset level, chooses an operation with four static mode-select inputs, and supplies bytes on an 8-bit data port. The block keeps its own 12-bit address counter. The counter is cleared when the reset level rises and moves forward one step on each rising edge of a step strobe. From these inputs the block issues read, byte-write and erase commands to the code array, which sits outside the block.

A byte write, or a write of a protection bit, starts on the rising edge of an active-low program strobe. It then runs for a fixed number of clock cycles set by a parameter. Progress can be seen in two ways: on a ready output, and by data polling, where bit 7 of the byte being written reads back inverted. Two protection bits narrow what is allowed. Only a chip erase clears them, and a chip erase needs the program strobe held low for a minimum time.

Top module: `flash_prog_ctrl`

## Requirements
- R1: A rising edge on `prog_rst` sets the address counter to 000h at the next clock edge.
- R2: Each rising edge on `addr_step` adds one to the address counter. The counter wraps from FFFh to 000h.
- R3: With `hv_en`=1 and `mode_sel`=4'b0111, a rising edge of `prog_strobe_n` starts a byte write. `rdy` is low from the next clock edge for exactly WR_CYCLES cycles. The array is then written and `rdy` returns high.
- R4: With `prog_rst`=1, `hv_en`=0, `prog_strobe_n`=1 and `mode_sel`=4'b0011, the block performs a code read. `data_oe` is 1 and `data_out` shows the array byte at the counter address.
- R5: While a byte write is busy, a code read of that same address returns the written byte with bit 7 inverted.
- R6: A byte write can only clear bits. The stored value becomes the old byte AND the new data.
- R7: With `hv_en`=1, `mode_sel`=4'b1111 writes protection bit A and 4'b1100 writes protection bit B. Each write is timed like a byte write, with `rdy` low.
- R8: When protection bit A is set, byte-write requests are ignored. `rdy` stays high and the array does not change. Code reads still work when only bit A is set.
- R9: When both protection bits are set, code reads return FFh.
- R10: With `hv_en`=1 and `mode_sel`=4'b1000, a chip erase happens when `prog_strobe_n` rises after being low for at least ERASE_CYCLES clock cycles. The erase sets every byte to FFh and clears both protection bits. A shorter low pulse has no effect.
- R11: With the read conditions of R4 and `mode_sel`=4'b0000, the block returns identification bytes: 1Eh at address 000h, 41h at 001h, and FFh at any other address. These reads work whatever the protection bits are set to.
- R12: `data_oe` is 0 whenever `hv_en`=1, `prog_rst`=0, `prog_strobe_n`=0 or the mode is not a read mode. `data_out` is 00h in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hv_en | input | 1 | High-voltage enable level; allows writes and erase |
| prog_rst | input | 1 | Programming reset level; rising edge clears the address |
| addr_step | input | 1 | Address increment strobe |
| prog_strobe_n | input | 1 | Active-low program strobe |
| mode_sel | input | 4 | Static operation select |
| data_in | input | 8 | Data from the programmer |
| data_out | output | 8 | Data to the programmer |
| data_oe | output | 1 | Output enable for the data port |
| rdy | output | 1 | High when ready, low while a write is running |
| mem_addr | output | 12 | Array address |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | Array byte write, one cycle |
| mem_erase | output | 1 | Array bulk erase, one cycle |
| mem_rdata | input | 8 | Array read data at `mem_addr` |

## Verification
An address counter that has drifted shows up at the first read after it. The byte returned comes from the wrong location, and the wrap test only passes if every one of 4096 steps was counted. A stuck sequencer shows within one cycle of the program strobe rising, as a wrong `rdy` level. A wrong write length shows as a different number of busy cycles. If a protection bit is lost or set by mistake, the next read or write request shows it through a returned FFh, a silent write, or a write that goes ahead when it should not.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam logic [3:0] MD_SIG   = 4'b0000;
  localparam logic [3:0] MD_READ  = 4'b0011;
  localparam logic [3:0] MD_PROG  = 4'b0111;
  localparam logic [3:0] MD_ERASE = 4'b1000;
  localparam logic [3:0] MD_LOCKB = 4'b1100;
  localparam logic [3:0] MD_LOCKA = 4'b1111;

  localparam logic [7:0] ID_BYTE0 = 8'h1E;
  localparam logic [7:0] ID_BYTE1 = 8'h41;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BYTE = 2'd1,
    ST_LOCK = 2'd2
  } seq_st_e;
endpackage

// File: rtl/fpc_edge_det.sv
module fpc_edge_det #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= sig;
  end

  assign rise = sig & ~prev_q;
endmodule

// File: rtl/fpc_addr_ctr.sv
module fpc_addr_ctr #(
  parameter int unsigned AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (clr)       addr_d = '0;
    else if (step) addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/fpc_seq.sv
module fpc_seq
  import fpc_pkg::*;
#(
  parameter int unsigned AW           = 12,
  parameter int unsigned WR_CYCLES    = 150,
  parameter int unsigned ERASE_CYCLES = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hv_en,
  input  logic          prog_rise,
  input  logic          prog_low,
  input  logic [3:0]    mode,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic [7:0]    mem_rdata,
  output logic          busy,
  output logic          byte_busy,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  output logic          mem_erase,
  output logic          lock_a,
  output logic          lock_b
);
  localparam int unsigned TW = $clog2(WR_CYCLES + 1);
  localparam int unsigned EW = $clog2(ERASE_CYCLES + 1);
  localparam logic [TW-1:0] T_LOAD = TW'(WR_CYCLES - 1);
  localparam logic [EW-1:0] E_MIN  = EW'(ERASE_CYCLES);

  seq_st_e       st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [AW-1:0] wa_q, wa_d;
  logic [7:0]    wd_q, wd_d;
  logic          lsel_q, lsel_d;
  logic          lka_q, lka_d, lkb_q, lkb_d;
  logic [EW-1:0] lc_q, lc_d;
  logic          start;

  always_comb begin
    st_d      = st_q;
    tmr_d     = tmr_q;
    wa_d      = wa_q;
    wd_d      = wd_q;
    lsel_d    = lsel_q;
    lka_d     = lka_q;
    lkb_d     = lkb_q;
    mem_we    = 1'b0;
    mem_erase = 1'b0;
    // erase hold counter: counts low cycles of the strobe, saturating
    if (prog_low && hv_en && (mode == MD_ERASE))
      lc_d = (lc_q == E_MIN) ? lc_q : lc_q + 1'b1;
    else
      lc_d = '0;
    start = prog_rise && hv_en && (st_q == ST_IDLE);

    if (st_q != ST_IDLE) begin
      if (tmr_q == '0) begin
        st_d = ST_IDLE;
        if (st_q == ST_BYTE) mem_we = 1'b1;
        else if (lsel_q)     lkb_d  = 1'b1;
        else                 lka_d  = 1'b1;
      end else begin
        tmr_d = tmr_q - 1'b1;
      end
    end else if (start) begin
      case (mode)
        MD_PROG: if (!lka_q) begin
          st_d  = ST_BYTE;
          tmr_d = T_LOAD;
          wa_d  = addr;
          wd_d  = din;
        end
        MD_LOCKA: begin
          st_d   = ST_LOCK;
          tmr_d  = T_LOAD;
          lsel_d = 1'b0;
        end
        MD_LOCKB: begin
          st_d   = ST_LOCK;
          tmr_d  = T_LOAD;
          lsel_d = 1'b1;
        end
        MD_ERASE: if (lc_q >= E_MIN) begin
          mem_erase = 1'b1;
          lka_d     = 1'b0;
          lkb_d     = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      tmr_q  <= '0;
      wa_q   <= '0;
      wd_q   <= '0;
      lsel_q <= 1'b0;
      lka_q  <= 1'b0;
      lkb_q  <= 1'b0;
      lc_q   <= '0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      wa_q   <= wa_d;
      wd_q   <= wd_d;
      lsel_q <= lsel_d;
      lka_q  <= lka_d;
      lkb_q  <= lkb_d;
      lc_q   <= lc_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign byte_busy = (st_q == ST_BYTE);
  assign wr_addr   = wa_q;
  assign wr_data   = wd_q;
  assign mem_wdata = mem_rdata & wd_q;
  assign lock_a    = lka_q;
  assign lock_b    = lkb_q;
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import fpc_pkg::*;
#(
  parameter int unsigned AW           = 12,
  parameter int unsigned WR_CYCLES    = 150,
  parameter int unsigned ERASE_CYCLES = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hv_en,
  input  logic          prog_rst,
  input  logic          addr_step,
  input  logic          prog_strobe_n,
  input  logic [3:0]    mode_sel,
  input  logic [7:0]    data_in,
  output logic [7:0]    data_out,
  output logic          data_oe,
  output logic          rdy,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          mem_we,
  output logic          mem_erase,
  input  logic [7:0]    mem_rdata
);
  logic [2:0]    rise;
  logic [AW-1:0] addr_q;
  logic          busy, byte_busy, lock_a, lock_b;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          rd_mode;
  logic [7:0]    rd_val;

  fpc_edge_det #(.W(3), .RST_VAL(3'b100)) edge_i (
    .clk(clk), .rst_n(rst_n),
    .sig({prog_strobe_n, addr_step, prog_rst}),
    .rise(rise)
  );

  fpc_addr_ctr #(.AW(AW)) ctr_i (
    .clk(clk), .rst_n(rst_n),
    .clr(rise[0]), .step(rise[1]),
    .addr(addr_q)
  );

  fpc_seq #(.AW(AW), .WR_CYCLES(WR_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .hv_en(hv_en), .prog_rise(rise[2]), .prog_low(!prog_strobe_n),
    .mode(mode_sel), .addr(addr_q), .din(data_in), .mem_rdata(mem_rdata),
    .busy(busy), .byte_busy(byte_busy), .wr_addr(wr_addr), .wr_data(wr_data),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_erase(mem_erase),
    .lock_a(lock_a), .lock_b(lock_b)
  );

  assign mem_addr = mem_we ? wr_addr : addr_q;
  assign rdy      = !busy;
  assign rd_mode  = prog_rst && !hv_en && prog_strobe_n &&
                    ((mode_sel == MD_READ) || (mode_sel == MD_SIG));

  always_comb begin
    if (mode_sel == MD_SIG) begin
      if (addr_q == AW'(0))      rd_val = ID_BYTE0;
      else if (addr_q == AW'(1)) rd_val = ID_BYTE1;
      else                       rd_val = 8'hFF;
    end else if (lock_a && lock_b) begin
      rd_val = 8'hFF;
    end else if (byte_busy && (addr_q == wr_addr)) begin
      rd_val = {~wr_data[7], wr_data[6:0]};
    end else begin
      rd_val = mem_rdata;
    end
  end

  assign data_oe  = rd_mode;
  assign data_out = rd_mode ? rd_val : 8'h00;
endmodule

// File: rtl/fpc_chk.sv
module fpc_chk
  import fpc_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hv_en,
  input logic          prog_rst,
  input logic          addr_step,
  input logic          prog_strobe_n,
  input logic [3:0]    mode_sel,
  input logic [AW-1:0] addr_q,
  input logic          rdy,
  input logic          mem_we,
  input logic          mem_erase,
  input logic          lock_a,
  input logic          lock_b,
  input logic          data_oe,
  input logic [7:0]    data_out
);
  assert_addr_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_rst) |=> (addr_q == '0));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(addr_step) && !$rose(prog_rst)) |=> (addr_q == AW'($past(addr_q) + 1'b1)));

  assert_busy_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(prog_strobe_n) && hv_en && (mode_sel == MD_PROG) && !lock_a && rdy) |=> !rdy);

  assert_write_ends_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> rdy);

  assert_locked_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(prog_strobe_n) && hv_en && (mode_sel == MD_PROG) && lock_a && rdy) |=> rdy);

  assert_verify_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && (mode_sel == MD_READ) && lock_a && lock_b) |-> (data_out == 8'hFF));

  assert_erase_unlock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_erase |=> (!lock_a && !lock_b));

  assert_no_drive_hv_R12: assert property (@(posedge clk) disable iff (!rst_n)
    hv_en |-> !data_oe);
endmodule

bind flash_prog_ctrl fpc_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .hv_en(hv_en), .prog_rst(prog_rst),
  .addr_step(addr_step), .prog_strobe_n(prog_strobe_n), .mode_sel(mode_sel),
  .addr_q(addr_q), .rdy(rdy), .mem_we(mem_we), .mem_erase(mem_erase),
  .lock_a(lock_a), .lock_b(lock_b), .data_oe(data_oe), .data_out(data_out)
);

// File: tb/flash_prog_ctrl_tb_top.sv
module flash_prog_ctrl_tb_top;
  localparam int W = 12;
  localparam int E = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       hv_en, prog_rst, addr_step, prog_strobe_n;
  logic [3:0] mode_sel;
  logic [7:0] data_in, data_out, mem_wdata, mem_rdata;
  logic       data_oe, rdy, mem_we, mem_erase;
  logic [11:0] mem_addr;
  logic [7:0] arr [0:4095];

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [7:0] exp_q [$];
  string      req_q [$];
  bit         mon_en = 1'b0;

  always #4 clk = ~clk;

  flash_prog_ctrl #(.AW(12), .WR_CYCLES(W), .ERASE_CYCLES(E)) dut_i (
    .clk(clk), .rst_n(rst_n), .hv_en(hv_en), .prog_rst(prog_rst),
    .addr_step(addr_step), .prog_strobe_n(prog_strobe_n), .mode_sel(mode_sel),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe), .rdy(rdy),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_erase(mem_erase), .mem_rdata(mem_rdata)
  );

  // behavioural code array
  assign mem_rdata = arr[mem_addr];
  always @(posedge clk) begin
    if (!rst_n || mem_erase) begin
      for (int i = 0; i < 4096; i++) arr[i] <= 8'hFF;
    end else if (mem_we) begin
      arr[mem_addr] <= mem_wdata;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_en && exp_q.size() > 0) begin
      logic [7:0] e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      tests++;
      if (!data_oe || data_out !== e) begin
        fails++;
        $display("FAIL %s: data_out=%h oe=%b expected=%h oe=1", r, data_out, data_oe, e);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic read_exp(input logic [3:0] md, input logic [7:0] e, input string req);
    hv_en = 1'b0; mode_sel = md;
    exp_q.push_back(e); req_q.push_back(req);
    mon_en = 1'b1;
    @(negedge clk); #1;
    mon_en = 1'b0;
  endtask

  task automatic goto_addr(input int n);
    prog_rst = 1'b0; step();
    prog_rst = 1'b1; step();
    for (int i = 0; i < n; i++) begin
      addr_step = 1'b1; step();
      addr_step = 1'b0; step();
    end
  endtask

  task automatic strobe(input logic [3:0] md, input logic [7:0] d, input int low);
    hv_en = 1'b1; mode_sel = md; data_in = d; step();
    prog_strobe_n = 1'b0;
    repeat (low) step();
    prog_strobe_n = 1'b1; step();
  endtask

  task automatic wait_rdy(output int cnt);
    cnt = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (rdy) break;
      cnt++;
    end
    step();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int c;
    rst_n = 1'b0; hv_en = 1'b0; prog_rst = 1'b0; addr_step = 1'b0;
    prog_strobe_n = 1'b1; mode_sel = 4'b0011; data_in = 8'h00;
    repeat (3) step();
    rst_n = 1'b1; step();
    @(negedge clk);
    chk(rdy == 1'b1, "R3 reset rdy", rdy, 1);
    chk(data_oe == 1'b0 && data_out == 8'h00, "R12 no read when prog_rst low", data_oe, 0);

    goto_addr(0);
    read_exp(4'b0011, 8'hFF, "R4 blank read");

    // R3 byte write timing
    strobe(4'b0111, 8'hA5, 2);
    @(negedge clk);
    chk(rdy == 1'b0, "R3 busy after strobe", rdy, 0);
    c = 1;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (rdy) break;
      c++;
    end
    chk(c == W, "R3 busy length", c, W);
    step();
    read_exp(4'b0011, 8'hA5, "R3 written byte");

    // R2 and R5 data polling
    goto_addr(3);
    read_exp(4'b0011, 8'hFF, "R2 step to 3");
    strobe(4'b0111, 8'h3C, 1);
    read_exp(4'b0011, 8'hBC, "R5 polling inverted bit7");
    wait_rdy(c);
    read_exp(4'b0011, 8'h3C, "R5 true data after busy");
    strobe(4'b0111, 8'hF0, 1);
    wait_rdy(c);
    read_exp(4'b0011, 8'h30, "R6 bits only cleared");

    // R2 wrap and R1 clear
    goto_addr(0);
    for (int i = 0; i < 4096; i++) begin
      addr_step = 1'b1; step();
      addr_step = 1'b0; step();
    end
    read_exp(4'b0011, 8'hA5, "R2 wrap to 000");
    goto_addr(3);
    goto_addr(0);
    read_exp(4'b0011, 8'hA5, "R1 clear on rise");

    // R11 identification
    read_exp(4'b0000, 8'h1E, "R11 id byte 0");
    addr_step = 1'b1; step(); addr_step = 1'b0; step();
    read_exp(4'b0000, 8'h41, "R11 id byte 1");
    addr_step = 1'b1; step(); addr_step = 1'b0; step();
    read_exp(4'b0000, 8'hFF, "R11 id other");

    // R10 short erase ignored
    goto_addr(0);
    strobe(4'b1000, 8'h00, E / 2);
    @(negedge clk);
    chk(rdy == 1'b1, "R10 short erase no busy", rdy, 1);
    read_exp(4'b0011, 8'hA5, "R10 short erase ignored");

    // R7 protection bit A, R8
    strobe(4'b1111, 8'h00, 1);
    @(negedge clk);
    chk(rdy == 1'b0, "R7 lock write busy", rdy, 0);
    wait_rdy(c);
    goto_addr(1);
    strobe(4'b0111, 8'h00, 1);
    @(negedge clk);
    chk(rdy == 1'b1, "R8 locked write no busy", rdy, 1);
    repeat (W + 2) step();
    read_exp(4'b0011, 8'hFF, "R8 locked write ignored");
    goto_addr(0);
    read_exp(4'b0011, 8'hA5, "R8 verify allowed with A only");

    // R9 both bits
    strobe(4'b1100, 8'h00, 1);
    wait_rdy(c);
    read_exp(4'b0011, 8'hFF, "R9 verify blocked");
    read_exp(4'b0000, 8'h1E, "R11 id with locks");
    hv_en = 1'b1; mode_sel = 4'b0011; step();
    @(negedge clk);
    chk(data_oe == 1'b0, "R12 no read with hv_en", data_oe, 0);

    // R10 full erase
    strobe(4'b1000, 8'h00, E + 2);
    read_exp(4'b0011, 8'hFF, "R10 erased addr 0");
    goto_addr(3);
    read_exp(4'b0011, 8'hFF, "R10 erased addr 3");
    goto_addr(0);
    strobe(4'b0111, 8'h5A, 1);
    wait_rdy(c);
    read_exp(4'b0011, 8'h5A, "R10 locks cleared");

    repeat (2) step();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule